// File: doc/BRIEF.md
# Dual-Tone Keypad Frequency Decoder

This block decodes telephone keypad dual-tone signalling from two squared inputs. Analog circuits outside the block split the line signal into a low band and a high band and limit each band to a logic-level square wave. Each of these two waves arrives on its own input pin. The block measures the period of each wave by counting system clocks between rising edges. It compares each period with the four standard tones of that band.

A band counts as holding a tone only after several consecutive periods land in the window of the same tone. A single stray period therefore cannot produce a detection, and speech and noise seldom can. While both bands hold a valid tone, the early-steering output is high and the output code identifies the pair. A duration guard placed after this block decides when a key press is registered.

The clock rate is a parameter. Its default is the 3.579545 MHz television colour-burst crystal, and all period windows are derived from it when the design is elaborated.

Top module: `dtmf_count_decoder`

## Requirements
- R1: A band's period p, in clocks between successive rising edges, matches tone i of that band when floor(N_i*(TOL_DIV-1)/TOL_DIV) <= p <= floor(N_i*(TOL_DIV+1)/TOL_DIV), where N_i = floor(CLK_HZ/f_i) and TOL_DIV defaults to 40 (±2.5 %). A period one clock outside this window matches nothing.
- R2: A band becomes valid only after AVG_N (default 4) consecutive periods match the same tone. The first rising edge after reset or after a timeout only starts a measurement and produces no period.
- R3: A single period that matches no tone clears the band's run. The band is invalid until AVG_N fresh matching periods have been seen.
- R4: A period that matches a tone different from the running one restarts the run at one, counted for the new tone.
- R5: est_o goes high one clock after both bands become valid. This is the third clock edge after the edge that first samples the completing rising input edge.
- R6: est_o goes low one clock after either band stops being valid.
- R7: code_o = {high_idx, low_idx}. Each 2-bit index orders its band by ascending frequency: low band 697, 770, 852, 941 Hz = 0..3, high band 1209, 1336, 1477, 1633 Hz = 0..3. code_o is loaded on the edge where est_o rises or stays high, and it holds its value while est_o is low.
- R8: If a band sees no rising edge for LIMIT clocks, that band becomes invalid and must re-arm. LIMIT = W + W/4, where W is the upper window bound (R1) of the band's lowest tone.
- R9: After reset, est_o = 0 and code_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock at CLK_HZ |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tone_lo_i | input | 1 | Squared low-band signal, asynchronous |
| tone_hi_i | input | 1 | Squared high-band signal, asynchronous |
| est_o | output | 1 | Early steering: both bands hold a valid tone |
| code_o | output | 4 | Tone-pair code {high_idx, low_idx} |

## Verification
Each input rising edge passes through a two-flop synchronizer and is then acted on by the run counter at the third clock edge after it was driven. est_o and code_o follow one edge after that. The bench's reference model keeps a short history of sampled inputs and applies the same edge counts. It compares est_o and code_o at every falling clock edge, where no output is still changing. Scenario checks are placed many tone periods after each stimulus change, so that they read settled values for acceptance, rejection at the window edges, a single bad period, a tone change and a timeout.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

  typedef logic [1:0] tone_idx_t;

  function automatic int unsigned tone_hz(input bit hi_grp, input int unsigned idx);
    int unsigned f;
    if (!hi_grp) begin
      case (idx)
        0:       f = 697;
        1:       f = 770;
        2:       f = 852;
        default: f = 941;
      endcase
    end else begin
      case (idx)
        0:       f = 1209;
        1:       f = 1336;
        2:       f = 1477;
        default: f = 1633;
      endcase
    end
    return f;
  endfunction

  function automatic int unsigned nominal_cycles(input int unsigned clk_hz, input bit hi_grp,
                                                 input int unsigned idx);
    return clk_hz / tone_hz(hi_grp, idx);
  endfunction

  function automatic int unsigned win_lo(input int unsigned n, input int unsigned tol_div);
    return n * (tol_div - 1) / tol_div;
  endfunction

  function automatic int unsigned win_hi(input int unsigned n, input int unsigned tol_div);
    return n * (tol_div + 1) / tol_div;
  endfunction

endpackage

// File: rtl/edge_sync.sv
module edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [2:0] sq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sq <= '0;
    else         sq <= {sq[1:0], async_i};
  end

  assign rise_o = sq[1] & ~sq[2];
endmodule

// File: rtl/period_counter.sv
module period_counter #(
  parameter int unsigned LIMIT = 1000,
  localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rise_i,
  output logic [CW-1:0] period_o,
  output logic          timeout_o
);
  logic [CW-1:0] cnt_q;

  assign timeout_o = (cnt_q == CW'(LIMIT));
  assign period_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (rise_i)     cnt_q <= CW'(1);
    else if (!timeout_o) cnt_q <= cnt_q + CW'(1);
  end

  // R8
  cnt_ceiling_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o && !rise_i |=> timeout_o);
endmodule

// File: rtl/bin_match.sv
module bin_match #(
  parameter int unsigned CLK_HZ  = 3579545,
  parameter bit          HI_GRP  = 1'b0,
  parameter int unsigned TOL_DIV = 40,
  parameter int unsigned CW      = 13
) (
  input  logic                [CW-1:0] period_i,
  output logic                         hit_o,
  output dtmf_pkg::tone_idx_t          bin_o
);
  logic [3:0] in_win;

  for (genvar i = 0; i < 4; i++) begin : g_win
    localparam int unsigned NOM = dtmf_pkg::nominal_cycles(CLK_HZ, HI_GRP, i);
    localparam int unsigned LO  = dtmf_pkg::win_lo(NOM, TOL_DIV);
    localparam int unsigned HI  = dtmf_pkg::win_hi(NOM, TOL_DIV);
    assign in_win[i] = (period_i >= CW'(LO)) && (period_i <= CW'(HI));
  end

  always_comb begin
    hit_o = 1'b0;
    bin_o = '0;
    for (int i = 3; i >= 0; i--) begin
      if (in_win[i]) begin
        hit_o = 1'b1;
        bin_o = 2'(i);
      end
    end
  end

  // R1 windows never overlap
  win_excl_chk: assert property (@(period_i) $onehot0(in_win));
endmodule

// File: rtl/tone_channel.sv
module tone_channel #(
  parameter int unsigned CLK_HZ     = 3579545,
  parameter bit          HI_GRP     = 1'b0,
  parameter int unsigned TOL_DIV    = 40,
  parameter int unsigned AVG_N      = 4,
  parameter int unsigned MARGIN_DIV = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tone_i,
  output logic                valid_o,
  output dtmf_pkg::tone_idx_t idx_o
);
  localparam int unsigned W0    = dtmf_pkg::win_hi(dtmf_pkg::nominal_cycles(CLK_HZ, HI_GRP, 0), TOL_DIV);
  localparam int unsigned LIMIT = W0 + W0 / MARGIN_DIV;
  localparam int unsigned CW    = $clog2(LIMIT + 1);
  localparam int unsigned RW    = $clog2(AVG_N + 1);

  logic                rise, timeout, hit, primed_q;
  logic [CW-1:0]       period;
  logic [RW-1:0]       run_q;
  dtmf_pkg::tone_idx_t bin, last_q;

  edge_sync i_sync (.clk_i, .rst_ni, .async_i(tone_i), .rise_o(rise));

  period_counter #(.LIMIT(LIMIT)) i_cnt (
    .clk_i, .rst_ni, .rise_i(rise), .period_o(period), .timeout_o(timeout));

  bin_match #(.CLK_HZ(CLK_HZ), .HI_GRP(HI_GRP), .TOL_DIV(TOL_DIV), .CW(CW)) i_bin (
    .period_i(period), .hit_o(hit), .bin_o(bin));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed_q <= 1'b0;
      run_q    <= '0;
      last_q   <= '0;
    end else if (rise) begin
      primed_q <= 1'b1;
      if (primed_q) begin
        if (!hit) run_q <= '0;
        else if (bin == last_q) begin
          if (run_q != RW'(AVG_N)) run_q <= run_q + RW'(1);
        end else begin
          last_q <= bin;
          run_q  <= RW'(1);
        end
      end
    end else if (timeout) begin
      primed_q <= 1'b0;
      run_q    <= '0;
    end
  end

  assign valid_o = (run_q == RW'(AVG_N));
  assign idx_o   = last_q;

  // R2
  valid_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(rise));
  // R3
  miss_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise && primed_q && !hit |=> !valid_o);
  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout && !rise |=> !valid_o);
endmodule

// File: rtl/dtmf_count_decoder.sv
module dtmf_count_decoder #(
  parameter int unsigned CLK_HZ     = 3579545,
  parameter int unsigned TOL_DIV    = 40,
  parameter int unsigned AVG_N      = 4,
  parameter int unsigned MARGIN_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tone_lo_i,
  input  logic       tone_hi_i,
  output logic       est_o,
  output logic [3:0] code_o
);
  logic [1:0]          tone_in, vld;
  dtmf_pkg::tone_idx_t idx [2];

  assign tone_in = {tone_hi_i, tone_lo_i};

  for (genvar g = 0; g < 2; g++) begin : g_band
    tone_channel #(
      .CLK_HZ(CLK_HZ), .HI_GRP(g == 1), .TOL_DIV(TOL_DIV),
      .AVG_N(AVG_N), .MARGIN_DIV(MARGIN_DIV)
    ) i_chan (
      .clk_i, .rst_ni, .tone_i(tone_in[g]), .valid_o(vld[g]), .idx_o(idx[g]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      est_o  <= 1'b0;
      code_o <= '0;
    end else begin
      est_o <= &vld;
      if (&vld) code_o <= {idx[1], idx[0]};
    end
  end

  // R5
  est_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(est_o) |-> $past(vld[0] && vld[1]));
  // R6
  est_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vld[0] && vld[1]) |=> !est_o);
  // R7
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_o) |-> est_o);
endmodule

// File: tb/test_dtmf_count_decoder.sv
module test_dtmf_count_decoder;
  localparam int CLK = 357954;
  localparam int TD  = 40;
  localparam int AVG = 4;

  logic clk = 1'b0, rst_n = 1'b0, tone_lo = 1'b0, tone_hi = 1'b0;
  logic est;
  logic [3:0] code;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  int per_lo = 0, per_hi = 0, ph_lo = 0, ph_hi = 0;

  always #5 clk = ~clk;

  dtmf_count_decoder #(.CLK_HZ(CLK)) i_dtmf_count_decoder (
    .clk_i(clk), .rst_ni(rst_n), .tone_lo_i(tone_lo), .tone_hi_i(tone_hi),
    .est_o(est), .code_o(code));

  function automatic int hz(int hi, int i);
    int lo_t[4] = '{697, 770, 852, 941};
    int hi_t[4] = '{1209, 1336, 1477, 1633};
    return hi ? hi_t[i] : lo_t[i];
  endfunction
  function automatic int nom(int hi, int i);  return CLK / hz(hi, i); endfunction
  function automatic int wlo(int hi, int i);  return nom(hi, i) * (TD - 1) / TD; endfunction
  function automatic int whi(int hi, int i);  return nom(hi, i) * (TD + 1) / TD; endfunction
  function automatic int lim(int hi);         return whi(hi, 0) + whi(hi, 0) / 4; endfunction

  // square-wave generators, one rising edge every per clocks
  always @(negedge clk) begin
    if (per_lo == 0) begin ph_lo = 0; tone_lo = 1'b0; end
    else begin ph_lo = ph_lo + 1; if (ph_lo >= per_lo) ph_lo = 0; tone_lo = (ph_lo < per_lo / 2); end
    if (per_hi == 0) begin ph_hi = 0; tone_hi = 1'b0; end
    else begin ph_hi = ph_hi + 1; if (ph_hi >= per_hi) ph_hi = 0; tone_hi = (ph_hi < per_hi / 2); end
  end

  // reference model
  int h1[2], h2[2], h3[2], m_cnt[2], m_prim[2], m_run[2], m_bin[2];
  int m_est = 0, m_code = 0;

  function automatic int classify(int g, int p);
    for (int i = 0; i < 4; i++) if (p >= wlo(g, i) && p <= whi(g, i)) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < 2; g++) begin
        h1[g] = 0; h2[g] = 0; h3[g] = 0; m_cnt[g] = 0; m_prim[g] = 0; m_run[g] = 0; m_bin[g] = 0;
      end
      m_est = 0; m_code = 0;
    end else begin
      bit both;
      both = (m_run[0] == AVG) && (m_run[1] == AVG);
      m_est = both;
      if (both) m_code = m_bin[1] * 4 + m_bin[0];
      for (int g = 0; g < 2; g++) begin
        int x, b;
        bit r;
        x = (g == 0) ? int'(tone_lo) : int'(tone_hi);
        r = (h2[g] == 1) && (h3[g] == 0);
        h3[g] = h2[g]; h2[g] = h1[g]; h1[g] = x;
        if (r) begin
          if (m_prim[g] == 1) begin
            b = classify(g, m_cnt[g]);
            if (b < 0) m_run[g] = 0;
            else if (b == m_bin[g]) begin if (m_run[g] < AVG) m_run[g]++; end
            else begin m_bin[g] = b; m_run[g] = 1; end
          end
          m_prim[g] = 1; m_cnt[g] = 1;
        end else if (m_cnt[g] == lim(g)) begin
          m_prim[g] = 0; m_run[g] = 0;
        end else m_cnt[g]++;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R5/R6/R7)
  always @(negedge clk) if (rst_n && !done) begin
    chk("R5/R6 est_o vs model", int'(est), m_est);
    chk("R7 code_o vs model", int'(code), m_code);
  end

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R9 est_o in reset", int'(est), 0);
    chk("R9 code_o in reset", int'(code), 0);
    rst_n = 1'b1;
    wait_cyc(2);
    chk("R9 est_o after reset", int'(est), 0);
    chk("R9 code_o after reset", int'(code), 0);

    // 697 + 1209
    per_lo = nom(0, 0); per_hi = nom(1, 0);
    wait_cyc(12 * nom(0, 0));
    chk("R5 est_o pair 0/0", int'(est), 1);
    chk("R7 code_o pair 0/0", int'(code), 4'h0);

    // change to 852 + 1336
    per_lo = nom(0, 2); per_hi = nom(1, 1);
    wait_cyc(12 * nom(0, 0));
    chk("R4 est_o after tone change", int'(est), 1);
    chk("R4 code_o after tone change", int'(code), 4'h6);

    // high band goes silent
    per_hi = 0;
    wait_cyc(lim(1) + 200);
    chk("R8 est_o after high timeout", int'(est), 0);
    chk("R6 est_o low with one band", int'(est), 0);
    chk("R7 code_o held while est low", int'(code), 4'h6);

    // restart both from silence: early check
    per_lo = 0;
    wait_cyc(lim(0) + 50);
    per_lo = nom(0, 3); per_hi = nom(1, 3);
    wait_cyc(3 * nom(0, 3));
    chk("R2 est_o before four periods", int'(est), 0);
    wait_cyc(10 * nom(0, 3));
    chk("R5 est_o pair 3/3", int'(est), 1);
    chk("R7 code_o pair 3/3", int'(code), 4'hF);

    // single bad low period
    per_lo = 600;
    @(posedge tone_lo);
    per_lo = nom(0, 3);
    wait_cyc(2 * nom(0, 3));
    chk("R3 est_o after one bad period", int'(est), 0);
    wait_cyc(10 * nom(0, 3));
    chk("R3 est_o recovered", int'(est), 1);

    // window edges on 697 Hz with 1477 Hz
    per_hi = nom(1, 2);
    per_lo = whi(0, 0) + 2;
    wait_cyc(12 * per_lo);
    chk("R1 est_o above upper bound", int'(est), 0);
    per_lo = whi(0, 0);
    wait_cyc(12 * per_lo);
    chk("R1 est_o at upper bound", int'(est), 1);
    chk("R1 code_o at upper bound", int'(code), 4'h8);
    per_lo = wlo(0, 0);
    wait_cyc(12 * per_lo);
    chk("R1 est_o at lower bound", int'(est), 1);
    per_lo = wlo(0, 0) - 1;
    wait_cyc(12 * per_lo);
    chk("R1 est_o below lower bound", int'(est), 0);
    chk("R7 code_o held after reject", int'(code), 4'h8);

    finish_run();
  end
endmodule